// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels behind a small register bus. Each channel owns a low and a high count register and a four-bit configuration field inside a shared mode register. A channel advances either once per clock (timer operation) or once per detected falling edge on its count pin (counter operation). It only advances while its run bit is set and, when gating is enabled, while its gate pin is high.

The same pair of count registers is read differently per mode:
- a 13-bit counter built from a 5-bit prescaler in the low register and 8 bits in the high register;
- a full 16-bit counter;
- an 8-bit counter with automatic reload from the high register;
- a split mode.

In split mode, channel 0 becomes two independent 8-bit counters. The second of these runs off channel 1's run bit and sets channel 1's flag. Channel 1 placed in the split mode simply stops.

Each channel raises a sticky overflow flag that software clears by writing the control register. External pins are brought into the clock domain through two-flop synchronizers.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset, every register reads 0 and both overflow flag outputs are 0.
- R2: A channel whose run bit is 0 holds its count. The run bits are control bit 4 (channel 0) and bit 6 (channel 1).
- R3: When a channel's gate bit is 1, it counts only while its synchronized gate pin is high. After the pin falls, at most two further increments occur. The gate bit is mode-field bit 3; channel 0's field is mode bits 3:0 and channel 1's is bits 7:4.
- R4: Mode 01 (field bits 1:0) is a 16-bit counter {high,low}. In timer operation (field bit 2 = 0) it advances once per clock. Passing FFFF to 0000 sets the channel's flag.
- R5: With field bit 2 = 1, a channel advances exactly once per falling edge of its count pin.
- R6: Mode 00 is a 13-bit counter. Bits 4:0 of the low register form the lower part; a carry out of 1F increments the high register. Low bits 7:5 read as 0. Passing high FF / low 1F sets the flag.
- R7: Mode 10 increments the low register. When low is FF, the next step loads low from the high register and sets the flag.
- R8: Mode 11 on channel 0 gives two counters. The low half obeys channel 0's run and gate bits and sets flag 0 on wrap. The high half advances once per clock while run bit 1 is set and sets flag 1 on wrap.
- R9: Mode 11 on channel 1 freezes channel 1's count.
- R10: While channel 0 is in mode 11, channel 1 keeps counting but its own overflow does not set flag 1.
- R11: Flags are control bit 5 (channel 0) and bit 7 (channel 1), mirrored on ovf_flag. A flag stays set until a control write stores 0 into it. A control write sets run and flag bits to the written values.
- R12: The bus addresses are 0 mode, 1 control, 2 and 3 for channel 0 low and high, and 4 and 5 for channel 1 low and high. A write takes effect at the next clock edge and overrides counting of that register. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one machine cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_pin | input | 2 | Count pins, one per channel |
| gate_pin | input | 2 | Gate pins, one per channel |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |

## Verification
Several rules are checked on every cycle:
- a stopped channel 0 holds its low count;
- channel 0 in timer mode 01 steps by exactly one;
- the 13-bit prescaler carries into the high byte;
- reload leaves low either at FF or at the high value;
- a frozen channel 1 stays put;
- flags never drop without a control write;
- in split mode, flag 1 cannot rise unless the high half of channel 0 was at FF.

Only the bench scenarios show the rest: exact counts after a known number of cycles, falling-edge counting through the synchronizer, the gate cut-off latency, reload and wrap values, and the flag ownership swap between channel 1 and the split high half.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, address map, control bit positions and the
// per-channel configuration layout of the dual timer/counter.
// Assumes two channels with 8-bit count registers.
package dtu_pkg;
    localparam int DW        = 8;   // register width
    localparam int NCH       = 2;   // channel count
    localparam int AW        = 3;   // bus address width
    localparam int CFG_W     = 4;   // mode field bits per channel
    localparam int PRE_W     = 5;   // prescaler bits in 13-bit mode
    localparam int SYNC_STG  = 2;   // synchronizer depth
    localparam int RUN_BASE  = 4;   // control bit of channel 0 run
    localparam int FLAG_BASE = 5;   // control bit of channel 0 flag
    localparam int CTL_STEP  = 2;   // spacing between channels in control

    localparam logic [AW-1:0] A_MODE = 3'd0;
    localparam logic [AW-1:0] A_CTRL = 3'd1;
    localparam logic [AW-1:0] A_LO0  = 3'd2;
    localparam logic [AW-1:0] A_HI0  = 3'd3;
    localparam logic [AW-1:0] A_LO1  = 3'd4;
    localparam logic [AW-1:0] A_HI1  = 3'd5;

    typedef enum logic [1:0] {
        MD_PRESCALED = 2'b00,
        MD_WIDE      = 2'b01,
        MD_RELOAD    = 2'b10,
        MD_SPLIT     = 2'b11
    } mode_e;

    typedef struct packed {
        logic  gate_en;
        logic  ext_cnt;
        mode_e mode;
    } chan_cfg_t;
endpackage

// File: rtl/dtu_sync.sv
`timescale 1ns/1ps
// Module: multi-bit level synchronizer, one flop chain per bit.
// Assumes inputs are asynchronous levels; STAGES must be at least 2.
module dtu_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    // Shift each input bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dtu_fall_det.sv
`timescale 1ns/1ps
// Module: falling-edge detector on already synchronized levels.
// Emits a one-clock pulse when a bit goes from 1 to 0. The history
// flop resets to 0, so a pin sitting high after reset gives no pulse.
module dtu_fall_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/dtu_count_core.sv
`timescale 1ns/1ps
// Module: next-state logic of one channel's count register pair.
// Purely combinational. inc_lo advances the main counter and inc_hi the
// split high half. SPLIT_OK selects whether mode 11 splits (1) or
// freezes (0) the channel. ovf_lo is the main overflow, ovf_hi the
// split high-half overflow.
module dtu_count_core
    import dtu_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  mode_e         mode,
    input  logic [DW-1:0] lo_q,
    input  logic [DW-1:0] hi_q,
    input  logic          inc_lo,
    input  logic          inc_hi,
    output logic [DW-1:0] lo_d,
    output logic [DW-1:0] hi_d,
    output logic          ovf_lo,
    output logic          ovf_hi
);
    localparam logic [DW-1:0]    ONE8  = DW'(1);
    localparam logic [PRE_W-1:0] ONEP  = PRE_W'(1);
    localparam logic [2*DW-1:0]  ONE16 = (2*DW)'(1);

    logic [PRE_W-1:0] pre;
    logic [2*DW-1:0]  wide;

    assign pre  = lo_q[PRE_W-1:0];
    assign wide = {hi_q, lo_q} + ONE16;

    // Compute the next register pair for the selected mode.
    always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        case (mode)
            MD_PRESCALED: begin
                if (inc_lo) begin
                    lo_d = {{(DW-PRE_W){1'b0}}, pre + ONEP};
                    if (&pre) begin
                        hi_d   = hi_q + ONE8;
                        ovf_lo = &hi_q;
                    end
                end
            end
            MD_WIDE: begin
                if (inc_lo) begin
                    {hi_d, lo_d} = wide;
                    ovf_lo       = &{hi_q, lo_q};
                end
            end
            MD_RELOAD: begin
                if (inc_lo) begin
                    if (&lo_q) begin
                        lo_d   = hi_q;
                        ovf_lo = 1'b1;
                    end else begin
                        lo_d = lo_q + ONE8;
                    end
                end
            end
            MD_SPLIT: begin
                if (SPLIT_OK) begin
                    if (inc_lo) begin
                        lo_d   = lo_q + ONE8;
                        ovf_lo = &lo_q;
                    end
                    if (inc_hi) begin
                        hi_d   = hi_q + ONE8;
                        ovf_hi = &hi_q;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_tmr_unit.sv
`timescale 1ns/1ps
// Module: dual timer/counter with a register bus.
// Two channels are configured by nibbles of the mode register and run or
// flagged through the control register. Pins are synchronized inside the
// block. A bus write beats counting for the register written.
module dual_tmr_unit
    import dtu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] cnt_pin,
    input  logic [NCH-1:0] gate_pin,
    output logic [NCH-1:0] ovf_flag
);
    localparam logic [DW-1:0] PRE_MASK = DW'((1 << PRE_W) - 1);

    logic [DW-1:0]  mode_q;
    logic [NCH-1:0] run_q, flag_q, flag_set;
    logic [DW-1:0]  lo_q [NCH];
    logic [DW-1:0]  hi_q [NCH];
    logic [DW-1:0]  lo_d [NCH];
    logic [DW-1:0]  hi_d [NCH];
    logic [DW-1:0]  rd_lo [NCH];
    logic [NCH-1:0] ovf_lo, ovf_hi, inc_lo, inc_hi;
    logic [NCH-1:0] cnt_lvl, cnt_fall, gate_lvl;
    chan_cfg_t      cfg [NCH];
    logic           split0;
    logic [DW-1:0]  ctrl_view;
    logic           wr_mode, wr_ctrl;

    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

    dtu_sync #(.W(NCH), .STAGES(SYNC_STG)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cnt_pin), .sync_o(cnt_lvl));

    dtu_sync #(.W(NCH), .STAGES(SYNC_STG)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_i(gate_pin), .sync_o(gate_lvl));

    dtu_fall_det #(.W(NCH)) u_fall (
        .clk(clk), .rst_n(rst_n), .level_i(cnt_lvl), .fall_o(cnt_fall));

    assign split0 = (cfg[0].mode == MD_SPLIT);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [AW-1:0] ADDR_LO = AW'(int'(A_LO0) + CTL_STEP * c);
        localparam logic [AW-1:0] ADDR_HI = AW'(int'(A_HI0) + CTL_STEP * c);

        logic enabled, step_evt;

        assign cfg[c]   = chan_cfg_t'(mode_q[c*CFG_W +: CFG_W]);
        assign enabled  = run_q[c] & (~cfg[c].gate_en | gate_lvl[c]);
        assign step_evt = cfg[c].ext_cnt ? cnt_fall[c] : 1'b1;
        assign inc_lo[c] = enabled & step_evt;
        // Only channel 0 has a split high half; it runs off run bit 1.
        assign inc_hi[c] = (c == 0) ? run_q[NCH-1] : 1'b0;

        dtu_count_core #(.SPLIT_OK(c == 0)) u_core (
            .mode  (cfg[c].mode),
            .lo_q  (lo_q[c]),
            .hi_q  (hi_q[c]),
            .inc_lo(inc_lo[c]),
            .inc_hi(inc_hi[c]),
            .lo_d  (lo_d[c]),
            .hi_d  (hi_d[c]),
            .ovf_lo(ovf_lo[c]),
            .ovf_hi(ovf_hi[c])
        );

        // Load the count pair from the bus or from the next-state logic.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[c] <= '0;
                hi_q[c] <= '0;
            end else begin
                lo_q[c] <= (bus_wr && bus_addr == ADDR_LO) ? bus_wdata : lo_d[c];
                hi_q[c] <= (bus_wr && bus_addr == ADDR_HI) ? bus_wdata : hi_d[c];
            end
        end

        assign rd_lo[c] = (cfg[c].mode == MD_PRESCALED) ? (lo_q[c] & PRE_MASK) : lo_q[c];
    end

    // Flag 0 comes from channel 0; flag 1 comes from the split high half
    // while channel 0 splits, otherwise from channel 1.
    assign flag_set[0] = ovf_lo[0];
    assign flag_set[1] = split0 ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);

    // Hold the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata;
    end

    // Run bits follow the bus; flags are sticky until a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
        end else if (wr_ctrl) begin
            for (int c = 0; c < NCH; c++) begin
                run_q[c]  <= bus_wdata[RUN_BASE + CTL_STEP * c];
                flag_q[c] <= bus_wdata[FLAG_BASE + CTL_STEP * c];
            end
        end else begin
            flag_q <= flag_q | flag_set;
        end
    end

    // Assemble the control register view.
    always_comb begin
        ctrl_view = '0;
        for (int c = 0; c < NCH; c++) begin
            ctrl_view[RUN_BASE + CTL_STEP * c]  = run_q[c];
            ctrl_view[FLAG_BASE + CTL_STEP * c] = flag_q[c];
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE) bus_rdata = mode_q;
        if (bus_addr == A_CTRL) bus_rdata = ctrl_view;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(int'(A_LO0) + CTL_STEP * c)) bus_rdata = rd_lo[c];
            if (bus_addr == AW'(int'(A_HI0) + CTL_STEP * c)) bus_rdata = hi_q[c];
        end
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/dtu_checker.sv
`timescale 1ns/1ps
// Module: cycle-level property checks for dual_tmr_unit, attached by bind.
// Observes the register state of the top module and the bus.
module dtu_checker
    import dtu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [3:0]    cfg0,
    input logic [1:0]    mode1,
    input logic          run0,
    input logic [1:0]    flags,
    input logic [DW-1:0] lo0,
    input logic [DW-1:0] hi0,
    input logic [DW-1:0] lo1,
    input logic [DW-1:0] hi1
);
    logic wr_c0, wr_c1, wr_ctl;
    assign wr_c0  = bus_wr && (bus_addr == A_LO0 || bus_addr == A_HI0);
    assign wr_c1  = bus_wr && (bus_addr == A_LO1 || bus_addr == A_HI1);
    assign wr_ctl = bus_wr && (bus_addr == A_CTRL);

    // R2: a stopped channel 0 keeps its low count.
    a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !wr_c0) |=> $stable(lo0));

    // R4: ungated timer in mode 01 steps by one each clock.
    a_r4_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0 == 4'b0001 && run0 && !bus_wr) |=> ({hi0, lo0} == $past({hi0, lo0}) + 16'd1));

    // R6: prescaler wrap carries into the high byte.
    a_r6_prescale_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0 == 4'b0000 && run0 && lo0[4:0] == 5'h1F && !bus_wr)
        |=> (lo0[4:0] == 5'h00 && hi0 == $past(hi0) + 8'd1));

    // R7: leaving FF in reload mode can only land on the high value.
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0[1:0] == 2'b10 && lo0 == 8'hFF && !bus_wr) |=> (lo0 == 8'hFF || lo0 == $past(hi0)));

    // R9: channel 1 in mode 11 is frozen.
    a_r9_ch1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 2'b11 && !wr_c1) |=> ($stable(lo1) && $stable(hi1)));

    // R10: in split mode flag 1 only rises from the high half wrapping.
    a_r10_split_flag_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0[1:0] == 2'b11 && !flags[1] && hi0 != 8'hFF && !wr_ctl) |=> !flags[1]);

    // R11: without a control write no flag is lost.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind dual_tmr_unit dtu_checker u_dtu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .cfg0    (mode_q[3:0]),
    .mode1   (mode_q[5:4]),
    .run0    (run_q[0]),
    .flags   (flag_q),
    .lo0     (lo_q[0]),
    .hi0     (hi_q[0]),
    .lo1     (lo_q[1]),
    .hi1     (hi_q[1])
);

// File: tb/dual_tmr_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table for channel 0 configurations, then directed tests.
module dual_tmr_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [2:0] AM = 3'd0, AC = 3'd1, L0 = 3'd2, H0 = 3'd3, L1 = 3'd4, H1 = 3'd5;

    dual_tmr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag));

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [7:0]  mode;
        logic [7:0]  ctrl;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] k;
        logic [7:0]  elo;
        logic [7:0]  ehi;
        logic [7:0]  ectl;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h01, 8'h10, 8'hFE, 8'hFF, 16'd3,  8'h01, 8'h00, 8'h30}, // R4 wrap
        '{8'h01, 8'h10, 8'h10, 8'h12, 16'd5,  8'h15, 8'h12, 8'h10}, // R4
        '{8'h00, 8'h10, 8'h1E, 8'h03, 16'd3,  8'h01, 8'h04, 8'h10}, // R6 carry
        '{8'h00, 8'h10, 8'h1F, 8'hFF, 16'd1,  8'h00, 8'h00, 8'h30}, // R6 wrap
        '{8'h00, 8'h10, 8'hFF, 8'h00, 16'd2,  8'h01, 8'h01, 8'h10}, // R6 mask
        '{8'h02, 8'h10, 8'hFD, 8'hA0, 16'd4,  8'hA1, 8'hA0, 8'h30}, // R7
        '{8'h02, 8'h10, 8'hFF, 8'hFF, 16'd3,  8'hFF, 8'hFF, 8'h30}, // R7 FF
        '{8'h03, 8'h10, 8'hF0, 8'h55, 16'd20, 8'h04, 8'h55, 8'h30}, // R8 low
        '{8'h03, 8'h40, 8'h11, 8'hFE, 16'd3,  8'h11, 8'h01, 8'hC0}, // R8 high
        '{8'h03, 8'h50, 8'h00, 8'h00, 16'd7,  8'h07, 8'h07, 8'h50}, // R8 both
        '{8'h01, 8'h00, 8'h34, 8'h12, 16'd10, 8'h34, 8'h12, 8'h00}, // R2
        '{8'h09, 8'h10, 8'h20, 8'h00, 16'd10, 8'h20, 8'h00, 8'h10}  // R3 gate low
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk("R1 reset reg", 3'(a), 8'h00);
        check("R1 reset flags", {6'd0, ovf_flag}, 8'h00);

        // Vector walk on channel 0
        for (int i = 0; i < NV; i++) begin
            wr(AC, 8'h00);
            wr(AM, VEC[i].mode);
            wr(L0, VEC[i].lo);
            wr(H0, VEC[i].hi);
            wr(AC, VEC[i].ctrl);
            repeat (int'(VEC[i].k)) @(negedge clk);
            rd_chk($sformatf("vector %0d low", i),  L0, VEC[i].elo);
            rd_chk($sformatf("vector %0d high", i), H0, VEC[i].ehi);
            rd_chk($sformatf("vector %0d ctrl", i), AC, VEC[i].ectl);
        end

        // R3 gate high counts, then stops two clocks after the pin falls
        wr(AC, 8'h00);
        gate_pin[0] = 1'b1;
        wr(AM, 8'h09);
        wr(L0, 8'h00);
        wr(H0, 8'h00);
        wr(AC, 8'h10);
        repeat (6) @(negedge clk);
        rd_chk("R3 gated count", L0, 8'h06);
        gate_pin[0] = 1'b0;
        repeat (10) @(negedge clk);
        rd_chk("R3 gate cut-off", L0, 8'h08);

        // R5 falling-edge counting
        wr(AC, 8'h00);
        wr(AM, 8'h05);
        wr(L0, 8'h00);
        wr(H0, 8'h00);
        wr(AC, 8'h10);
        for (int e = 0; e < 4; e++) begin
            cnt_pin[0] = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin[0] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd_chk("R5 edge count low", L0, 8'h04);
        rd_chk("R5 edge count high", H0, 8'h00);

        // R10 channel 1 counts but its wrap does not set flag 1 in split mode
        wr(AC, 8'h00);
        wr(AM, 8'h13);
        wr(L1, 8'hFE);
        wr(H1, 8'hFF);
        wr(L0, 8'h00);
        wr(H0, 8'h00);
        wr(AC, 8'h40);
        repeat (5) @(negedge clk);
        rd_chk("R10 ch1 low", L1, 8'h03);
        rd_chk("R10 ch1 high", H1, 8'h00);
        rd_chk("R10 flag1 clear", AC, 8'h40);
        rd_chk("R8 split high half", H0, 8'h05);

        // R10 contrast: without split, channel 1 wrap sets flag 1
        wr(AC, 8'h00);
        wr(AM, 8'h10);
        wr(L1, 8'hFF);
        wr(H1, 8'hFF);
        wr(AC, 8'h40);
        @(negedge clk);
        rd_chk("R10 ch1 own flag", AC, 8'hC0);

        // R11 flag sticks, then a control write clears it
        repeat (20) @(negedge clk);
        rd_chk("R11 flag sticky", AC, 8'hC0);
        check("R11 flag pins", {6'd0, ovf_flag}, 8'h02);
        wr(AC, 8'h40);
        rd_chk("R11 flag cleared", AC, 8'h40);
        check("R11 flag pins cleared", {6'd0, ovf_flag}, 8'h00);

        // R9 channel 1 mode 11 freezes
        wr(AC, 8'h00);
        wr(AM, 8'h30);
        wr(L1, 8'h22);
        wr(H1, 8'h33);
        wr(AC, 8'h40);
        repeat (10) @(negedge clk);
        rd_chk("R9 ch1 low frozen", L1, 8'h22);
        rd_chk("R9 ch1 high frozen", H1, 8'h33);

        // R12 bus read-back
        wr(AC, 8'h00);
        wr(L1, 8'hA5);
        rd_chk("R12 ch1 low readback", L1, 8'hA5);
        wr(AM, 8'hB6);
        rd_chk("R12 mode readback", AM, 8'hB6);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule